// File: doc/BRIEF.md
# Eight-Bit ALU with Flag Generation

This block is the arithmetic and logic stage of a small load/store processor. Each cycle it takes two 8-bit operands, an operation code and the flag values currently held by the processor. It produces the result to write back, a write-back enable, and the next Carry, Zero, Sign and Overflow values. Flag storage stays with the processor: it feeds its flag register back into `flags_in` and latches `flags_out`.

Each class of operation has its own rule for the flags. Add, subtract and compare produce an arithmetic carry or borrow and signed overflow. Compare computes the difference only for its flags and drops the write-back. The bitwise operations clear Carry and Overflow. The single-bit shifts move the bit pushed out into Carry. Rotate right takes its count from the second operand and leaves Carry and Overflow as they were. Move, and every operation code not listed, copies operand B and returns the incoming flags unchanged.

The result, the flags and the write-back enable are registered. They appear one clock after the operands are presented.

Top module: `alu8_core`

## Requirements
- R1: When `rst` is high at a rising edge, `result`, `flags_out` and `res_we` become zero after that edge.
- R2: The outputs for a set of inputs show up after the rising edge that samples those inputs, and not before it.
- R3: Add (`op_sel`=1) returns (A+B) mod 256. Carry is 1 when A+B > 255 unsigned. Overflow is 1 when the two's-complement sum is outside -128..127. The flag vector is bit 3 Carry, bit 2 Zero, bit 1 Sign, bit 0 Overflow.
- R4: Subtract (`op_sel`=2) returns (A-B) mod 256. Carry is 1 on a borrow (A < B unsigned). Overflow is 1 when the signs of A and B differ and the result sign differs from that of A.
- R5: Compare (`op_sel`=3) sets every flag exactly as subtract would, and holds `res_we` at 0. All other codes set `res_we` to 1.
- R6: AND (4), OR (5) and XOR (6) return the bitwise result and clear Carry and Overflow.
- R7: Shift left (8) returns A<<1 with Carry = A bit 7. Shift right (9) is logical, returns A>>1, and sets Carry = A bit 0. Both clear Overflow.
- R8: Rotate right (7) rotates A by B mod 8 places. This equals a left rotation by (8 - B mod 8) mod 8, so a count of 0 or 8 returns A unchanged. Carry and Overflow pass through from `flags_in`.
- R9: For codes 1 to 9, Zero is 1 exactly when the 8-bit result is 0x00, and Sign equals result bit 7.
- R10: Move (0) and the unassigned codes 10 to 15 return B and copy `flags_in` to `flags_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| opa | input | 8 | Operand A (the operand shifted or rotated) |
| opb | input | 8 | Operand B (addend, subtrahend, rotate count, move source) |
| flags_in | input | 4 | Current flags {C,Z,S,V} |
| result | output | 8 | Registered result |
| flags_out | output | 4 | Registered next flags {C,Z,S,V} |
| res_we | output | 1 | Registered write-back enable |

## Verification
Each result, flag vector and write-back enable is due exactly one rising edge after its inputs are driven. The bench drives on the falling edge and compares on the next falling edge. At that point, the outputs it compares belong to the inputs it drove half a cycle before the edge in between. The reference model keeps one pending expectation, so a check runs every cycle. One dedicated check samples the outputs just before the capturing edge to confirm that nothing appears early. The reset checks also look one edge after `rst` is raised.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_MOV = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_CMP = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_ROR = 4'd7,
    OP_SHL = 4'd8,
    OP_SHR = 4'd9
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         c,
  output logic         v
);
  localparam int MSB = W - 1;

  logic [W:0]   wide;
  logic [W-1:0] b_eff;

  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign res   = wide[W-1:0];
  // Carry out of the adder means "no borrow" when subtracting.
  assign c     = sub ? ~wide[W] : wide[W];
  assign v     = sub ? ((a[MSB] != b[MSB]) && (res[MSB] != a[MSB]))
                     : ((a[MSB] == b[MSB]) && (res[MSB] != a[MSB]));
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_r,
  output logic [W-1:0] or_r,
  output logic [W-1:0] xor_r,
  output logic [W-1:0] ror_r,
  output logic [W-1:0] shl_r,
  output logic [W-1:0] shr_r,
  output logic         shl_c,
  output logic         shr_c
);
  localparam int CW = $clog2(W);

  assign and_r = a & b;
  assign or_r  = a | b;
  assign xor_r = a ^ b;
  assign shl_r = {a[W-2:0], 1'b0};
  assign shr_r = {1'b0, a[W-1:1]};
  assign shl_c = a[W-1];
  assign shr_c = a[0];

  // Logarithmic rotator: stage s rotates right by 2**s when count bit s is set.
  logic [W-1:0] stg [0:CW];
  assign stg[0] = a;
  for (genvar s = 0; s < CW; s++) begin : g_rot
    localparam int SH = 1 << s;
    assign stg[s+1] = b[s] ? {stg[s][SH-1:0], stg[s][W-1:SH]} : stg[s];
  end
  assign ror_r = stg[CW];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] result,
  output logic [3:0]   flags_out,
  output logic         res_we
);
  localparam int CW = $clog2(W);

  alu_op_e    op;
  alu_flags_t fin, nxt_f, flg_q;
  logic [W-1:0] as_res, and_r, or_r, xor_r, ror_r, shl_r, shr_r, nxt_res;
  logic as_c, as_v, shl_c, shr_c, do_sub, nxt_we, upd;

  assign op     = alu_op_e'(op_sel);
  assign fin    = alu_flags_t'(flags_in);
  assign do_sub = (op == OP_SUB) || (op == OP_CMP);

  alu8_addsub #(.W(W)) u_addsub (
    .a(opa), .b(opb), .sub(do_sub), .res(as_res), .c(as_c), .v(as_v)
  );

  alu8_bitops #(.W(W)) u_bitops (
    .a(opa), .b(opb), .and_r(and_r), .or_r(or_r), .xor_r(xor_r),
    .ror_r(ror_r), .shl_r(shl_r), .shr_r(shr_r), .shl_c(shl_c), .shr_c(shr_c)
  );

  always_comb begin
    nxt_res = opb;
    nxt_f   = fin;
    nxt_we  = 1'b1;
    upd     = 1'b1;
    case (op)
      OP_ADD, OP_SUB: begin nxt_res = as_res; nxt_f.c = as_c; nxt_f.v = as_v; end
      OP_CMP: begin nxt_res = as_res; nxt_f.c = as_c; nxt_f.v = as_v; nxt_we = 1'b0; end
      OP_AND: begin nxt_res = and_r; nxt_f.c = 1'b0; nxt_f.v = 1'b0; end
      OP_OR:  begin nxt_res = or_r;  nxt_f.c = 1'b0; nxt_f.v = 1'b0; end
      OP_XOR: begin nxt_res = xor_r; nxt_f.c = 1'b0; nxt_f.v = 1'b0; end
      OP_ROR: nxt_res = ror_r;
      OP_SHL: begin nxt_res = shl_r; nxt_f.c = shl_c; nxt_f.v = 1'b0; end
      OP_SHR: begin nxt_res = shr_r; nxt_f.c = shr_c; nxt_f.v = 1'b0; end
      default: upd = 1'b0;
    endcase
    if (upd) begin
      nxt_f.z = (nxt_res == '0);
      nxt_f.s = nxt_res[W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flg_q  <= '0;
      res_we <= 1'b0;
    end else begin
      result <= nxt_res;
      flg_q  <= nxt_f;
      res_we <= nxt_we;
    end
  end

  assign flags_out = flg_q;

  AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd3) |=> !res_we); // R5
  AST_MOVE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd0) |=> (flags_out == $past(flags_in))); // R10
  AST_LOGIC_CLEARS_CV: assert property (@(posedge clk) disable iff (rst)
    (op_sel inside {4'd4, 4'd5, 4'd6}) |=> (!flags_out[3] && !flags_out[0])); // R6
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (op_sel inside {[4'd1:4'd9]}) |=> (flags_out[2] == (result == '0))); // R9
  AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (op_sel inside {[4'd1:4'd9]}) |=> (flags_out[1] == result[W-1])); // R9
  AST_ROR_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    ((op_sel == 4'd7) && (opb[CW-1:0] == '0)) |=> (result == $past(opa))); // R8
  AST_SHIFT_CLEARS_V: assert property (@(posedge clk) disable iff (rst)
    (op_sel inside {4'd8, 4'd9}) |=> !flags_out[0]); // R7
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_sel = '0;
  logic [7:0] opa = '0, opb = '0;
  logic [3:0] flags_in = '0;
  logic [7:0] result;
  logic [3:0] flags_out;
  logic       res_we;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit exp_ok = 0;
  int e_op, e_res, e_fl, e_we;

  always #5 clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb),
    .flags_in(flags_in), .result(result), .flags_out(flags_out), .res_we(res_we)
  );

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // Behavioural reference: returns {we, flags[3:0], result[7:0]} packed in an int.
  function automatic int model(input int op, input int a, input int b, input int fin);
    int r, c, z, s, v, we, upd, t, k;
    r = b; c = (fin >> 3) & 1; z = (fin >> 2) & 1; s = (fin >> 1) & 1; v = fin & 1;
    we = 1; upd = 1;
    case (op)
      1: begin t = a + b; r = t & 255; c = (t > 255); t = sgn(a) + sgn(b); v = (t > 127 || t < -128); end
      2, 3: begin
        r = (a - b) & 255; c = (a < b); t = sgn(a) - sgn(b); v = (t > 127 || t < -128);
        if (op == 3) we = 0;
      end
      4: begin r = a & b; c = 0; v = 0; end
      5: begin r = a | b; c = 0; v = 0; end
      6: begin r = a ^ b; c = 0; v = 0; end
      7: begin k = (8 - (b % 8)) % 8; r = ((a << k) | (a >> (8 - k))) & 255; end
      8: begin r = (a << 1) & 255; c = a >> 7; v = 0; end
      9: begin r = a >> 1; c = a & 1; v = 0; end
      default: upd = 0;
    endcase
    if (upd != 0) begin z = (r == 0); s = r >> 7; end
    return (we << 12) | (c << 11) | (z << 10) | (s << 9) | (v << 8) | r;
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      1: return "R3";  2: return "R4";  3: return "R5";
      4, 5, 6: return "R6";  7: return "R8";  8, 9: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d actual=%h expected=%h", tag, e_op, act, exp);
    end
  endtask

  // Compare the pending expectation, then drive the next inputs (all on the falling edge).
  task automatic step(input int op, input int a, input int b, input int fl);
    int m;
    @(negedge clk);
    if (exp_ok) begin
      check(tag_of(e_op), {res_we, result}, {e_we[0], e_res[7:0]});
      check(tag_of(e_op), {flags_out[3], flags_out[0]}, {e_fl[3], e_fl[0]});
      check((e_op >= 1 && e_op <= 9) ? "R9" : "R10", flags_out[2:1], e_fl[2:1]);
    end
    op_sel = op[3:0]; opa = a[7:0]; opb = b[7:0]; flags_in = fl[3:0];
    m = model(op, a, b, fl);
    e_op = op; e_res = m & 255; e_fl = (m >> 8) & 15; e_we = (m >> 12) & 1;
    exp_ok = 1;
  endtask

  initial begin
    op_sel = 4'd1; opa = 8'hFF; opb = 8'h01; flags_in = 4'hF;
    repeat (2) @(negedge clk);
    e_op = 1;
    check("R1", {res_we, flags_out, result}, 13'd0);
    rst = 1'b0;
    op_sel = 4'd1; opa = 8'd3; opb = 8'd4;
    #1 check("R2", {res_we, result}, 9'd0);  // R2: nothing before the capturing edge
    exp_ok = 0;
    // R3 add corners
    step(1, 200, 100, 0); step(1, 100, 50, 0); step(1, 128, 128, 0); step(1, 127, 1, 15);
    // R4 subtract corners
    step(2, 5, 10, 0); step(2, 128, 1, 0); step(2, 9, 9, 0); step(2, 0, 255, 15);
    // R5 compare
    step(3, 9, 9, 0); step(3, 3, 200, 0); step(3, 127, 255, 0);
    // R6 logic
    step(4, 240, 15, 15); step(5, 0, 0, 15); step(6, 170, 85, 9);
    // R8 rotate, counts 0, 8, 3, 15 with pass-through flags
    step(7, 165, 0, 9); step(7, 165, 8, 0); step(7, 1, 3, 8); step(7, 129, 15, 1);
    // R7 shifts
    step(8, 128, 0, 1); step(8, 65, 0, 0); step(9, 1, 0, 1); step(9, 130, 0, 0);
    // R10 move and unassigned codes
    step(0, 1, 0, 10); step(12, 7, 200, 5); step(15, 0, 0, 6);
    for (int i = 0; i < 600; i++)
      step($urandom_range(15), $urandom_range(255), $urandom_range(255), $urandom_range(15));
    step(0, 0, 0, 0);
    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1; op_sel = 4'd1; opa = 8'd255; opb = 8'd255; flags_in = 4'hF;
    @(negedge clk);
    check("R1", {res_we, flags_out, result}, 13'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000ns;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule